// File: doc/BRIEF.md
# Signature Comparator Watchdog with Dynamic Heartbeat

This block supervises a monitored processor by checking, one bit at a time, the signature that processor computes against an expected signature stored in an external read-only table. The block drives the table address itself. When a valid actual-signature bit arrives, it compares that bit with the table bit at the current address. On a match the address steps forward and wraps at the signature length.

Health is shown by a dynamic alarm. A two-bit heartbeat alternates between the complementary codes `10` and `01`, with each code held for 1 ms, which gives a 500 Hz square wave derived from the parameterized clock frequency. Three conditions flatline both heartbeat bits to `00`, and that state is held until reset:
- a mismatching bit,
- a stall of the valid strobe that lasts too long,
- a corrupted table address, which produces a mismatch.

A downstream fail-safe stage only needs to tell a toggling pair from a flat one.

Top module: `sig_watchdog`

## Requirements
- R1: After reset, `tbl_addr` is 0 and `beat` is `10`.
- R2: While no error is latched, `beat` alternates between `10` and `01`. Each code lasts HALF_CYC = CLK_HZ/(2*BEAT_HZ) clock cycles, which is 1 ms. The first change comes HALF_CYC rising edges after reset is released.
- R3: `exp_bit` is the table bit at the `tbl_addr` presented in the same cycle. When `act_vld` is 1 and `act_bit` equals `exp_bit`, `tbl_addr` advances by one on that edge, and it wraps from SIG_LEN-1 to 0.
- R4: When `act_vld` is 1 and `act_bit` differs from `exp_bit`, `beat` reads `00` from the next cycle on.
- R5: Once `beat` is `00`, it stays `00` and `tbl_addr` stays frozen until reset.
- R6: A heartbeat code change is called a boundary. If TMO_HALVES consecutive boundaries pass with no cycle in which `act_vld` is 1, `beat` becomes `00` on the edge of the last of those boundaries. A valid bit, including one on a boundary cycle, restarts this count.
- R7: `beat` never reads `11`.
- R8: When `act_vld` is 0, `act_bit` is ignored: `tbl_addr` holds and no error is raised by the bit value.
- R9: If the table is read at a corrupted address, here with the low three address bits forced to 0, the bits delivered differ from the true signature and `beat` flatlines to `00`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_bit | input | 1 | Serial bit of the computed signature |
| act_vld | input | 1 | Qualifies `act_bit` for this cycle |
| exp_bit | input | 1 | Read data of the expected-signature table |
| tbl_addr | output | $clog2(SIG_LEN) | Address into the expected-signature table |
| beat | output | 2 | Heartbeat pair: `10`/`01` alternating when healthy, `00` after an error |

## Verification
The bench checks the exact cycle at which the stall timeout expires, one edge before and one edge after the final boundary. A timer that counts one boundary too many or too few fails that check. It also checks the address wrap at a signature length that is not a power of two; a design that wraps at the power of two reads past the table and fails the address comparison. Long random runs mix valid bits with garbage on invalid cycles, which catches any design that samples `act_bit` without its strobe. Repeated mismatch and corrupted-address episodes confirm that the flatline arrives one cycle later, never shows `11`, and freezes the address; a design whose error was not sticky would resume toggling there.

// File: rtl/sigwd_pkg.sv
`timescale 1ns/1ps
package sigwd_pkg;

   localparam logic [1:0] BEAT_HI_LO = 2'b10;
   localparam logic [1:0] BEAT_LO_HI = 2'b01;
   localparam logic [1:0] BEAT_DEAD  = 2'b00;

   // Heartbeat code from the latched error and the current phase.
   function automatic logic [1:0] beat_code(input logic dead, input logic phase);
      if (dead)
         return BEAT_DEAD;
      return phase ? BEAT_HI_LO : BEAT_LO_HI;
   endfunction

endpackage

// File: rtl/sigwd_beat_div.sv
`timescale 1ns/1ps
module sigwd_beat_div #(
   parameter int HALF_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == CW'(HALF_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sigwd_addr_gen.sv
`timescale 1ns/1ps
module sigwd_addr_gen #(
   parameter int SIG_LEN = 12,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [ADDR_W-1:0] addr
);
   if (SIG_LEN == (1 << ADDR_W)) begin : g_pow2
      // The counter rolls over on its own at the table length.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            addr <= '0;
         else if (adv)
            addr <= addr + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            addr <= '0;
         else if (adv)
            addr <= (addr == ADDR_W'(SIG_LEN - 1)) ? '0 : addr + 1'b1;
      end
   end
endmodule

// File: rtl/sigwd_stall_timer.sv
`timescale 1ns/1ps
module sigwd_stall_timer #(
   parameter int TMO_HALVES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expired
);
   if (TMO_HALVES == 0) begin : g_off
      assign expired = 1'b0;
   end else begin : g_on
      localparam int SW = $clog2(TMO_HALVES + 1);
      logic [SW-1:0] cnt_q;

      assign expired = tick && !clr && (cnt_q == SW'(TMO_HALVES - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (clr)
            cnt_q <= '0;
         else if (tick && !expired)
            cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sig_watchdog.sv
`timescale 1ns/1ps
module sig_watchdog
   import sigwd_pkg::*;
#(
   parameter int CLK_HZ     = 16000,
   parameter int BEAT_HZ    = 500,
   parameter int SIG_LEN    = 12,
   parameter int TMO_HALVES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       act_bit,
   input  logic                       act_vld,
   input  logic                       exp_bit,
   output logic [$clog2(SIG_LEN)-1:0] tbl_addr,
   output logic [1:0]                 beat
);
   localparam int HALF_CYC = CLK_HZ / (2 * BEAT_HZ);
   localparam int ADDR_W   = $clog2(SIG_LEN);

   if (SIG_LEN < 2) begin : g_bad_len
      $error("sig_watchdog: SIG_LEN must be at least 2");
   end
   if (BEAT_HZ < 1 || HALF_CYC < 2) begin : g_bad_div
      $error("sig_watchdog: CLK_HZ must give at least two cycles per half period");
   end
   if (CLK_HZ % (2 * BEAT_HZ) != 0) begin : g_bad_ratio
      $error("sig_watchdog: CLK_HZ must be a multiple of 2*BEAT_HZ");
   end
   if (TMO_HALVES < 0) begin : g_bad_tmo
      $error("sig_watchdog: TMO_HALVES must not be negative");
   end

   logic tick;
   logic stall_exp;
   logic mismatch;
   logic advance;
   logic err_q;
   logic phase_q;

   assign mismatch = act_vld && (act_bit != exp_bit) && !err_q;
   assign advance  = act_vld && !mismatch && !err_q;

   sigwd_beat_div #(.HALF_CYC(HALF_CYC)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   sigwd_addr_gen #(.SIG_LEN(SIG_LEN), .ADDR_W(ADDR_W)) u_addr (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (advance),
      .addr (tbl_addr)
   );

   sigwd_stall_timer #(.TMO_HALVES(TMO_HALVES)) u_stall (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (act_vld),
      .tick   (tick),
      .expired(stall_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q   <= 1'b0;
         phase_q <= 1'b1;
      end else begin
         if (mismatch || stall_exp)
            err_q <= 1'b1;
         if (tick && !err_q)
            phase_q <= ~phase_q;
      end
   end

   assign beat = beat_code(err_q, phase_q);
endmodule

// File: rtl/sigwd_checker.sv
`timescale 1ns/1ps
module sigwd_checker #(
   parameter int SIG_LEN = 12,
   parameter int ADDR_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              act_bit,
   input logic              act_vld,
   input logic              exp_bit,
   input logic [ADDR_W-1:0] tbl_addr,
   input logic [1:0]        beat
);
   assert_never_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
      beat != 2'b11)
      else $error("beat shows 11");

   assert_flatline_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (beat == 2'b00) |=> (beat == 2'b00) && $stable(tbl_addr))
      else $error("error state not held");

   assert_mismatch_kills_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_vld && (act_bit != exp_bit)) |=> (beat == 2'b00))
      else $error("mismatch did not flatline");

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_vld && (act_bit == exp_bit) && (beat != 2'b00)) |=>
      (tbl_addr == (($past(tbl_addr) == ADDR_W'(SIG_LEN - 1)) ? '0 : $past(tbl_addr) + 1'b1)))
      else $error("address did not step");

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !act_vld |=> $stable(tbl_addr))
      else $error("address moved without valid bit");
endmodule

bind sig_watchdog sigwd_checker #(.SIG_LEN(SIG_LEN), .ADDR_W(ADDR_W)) u_sigwd_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .act_bit (act_bit),
   .act_vld (act_vld),
   .exp_bit (exp_bit),
   .tbl_addr(tbl_addr),
   .beat    (beat)
);

// File: tb/test_sig_watchdog.sv
`timescale 1ns/1ps
module test_sig_watchdog;
   localparam int CLK_HZ   = 16000;
   localparam int BEAT_HZ  = 500;
   localparam int SIG_LEN  = 12;
   localparam int TMO      = 4;
   localparam int HALF     = CLK_HZ / (2 * BEAT_HZ);
   localparam int AW       = $clog2(SIG_LEN);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          act_bit = 1'b0;
   logic          act_vld = 1'b0;
   logic          exp_bit;
   logic [AW-1:0] tbl_addr;
   logic [1:0]    beat;

   logic sig_mem [SIG_LEN];
   logic stuck = 1'b0;
   int   checks = 0;
   int   errors = 0;

   // Bench reference state
   int   m_addr, m_div, m_stall;
   logic m_err, m_phase;

   always #2 clk = ~clk;

   function automatic int tbl_idx(input int a, input logic st);
      return st ? (a & ~7) : a;
   endfunction

   assign exp_bit = sig_mem[tbl_idx(int'(tbl_addr), stuck)];

   sig_watchdog #(.CLK_HZ(CLK_HZ), .BEAT_HZ(BEAT_HZ), .SIG_LEN(SIG_LEN), .TMO_HALVES(TMO))
      i_sig_watchdog (
      .clk(clk), .rst_n(rst_n), .act_bit(act_bit), .act_vld(act_vld),
      .exp_bit(exp_bit), .tbl_addr(tbl_addr), .beat(beat));

   function automatic logic [1:0] m_beat();
      if (m_err) return 2'b00;
      return m_phase ? 2'b10 : 2'b01;
   endfunction

   always @(posedge clk) begin
      logic mm, tk;
      if (!rst_n) begin
         m_addr = 0; m_div = 0; m_stall = 0; m_err = 1'b0; m_phase = 1'b1;
      end else if (!m_err) begin
         mm = act_vld && (act_bit != sig_mem[tbl_idx(m_addr, stuck)]);
         tk = (m_div == HALF - 1);
         m_div = tk ? 0 : m_div + 1;
         if (mm) m_err = 1'b1;
         else begin
            if (act_vld) begin
               m_addr = (m_addr == SIG_LEN - 1) ? 0 : m_addr + 1;
               m_stall = 0;
            end else if (tk) begin
               if (m_stall == TMO - 1) m_err = 1'b1;
               else m_stall = m_stall + 1;
            end
            if (tk && !m_err) m_phase = ~m_phase;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, compare at the following negedge.
   task automatic cyc(input logic v, input logic b);
      act_vld = v; act_bit = b;
      @(posedge clk); @(negedge clk);
      chk(beat != 2'b11, "R7 beat never 11", beat, 1);
      chk(beat == m_beat(), "R2/R4/R6 beat", beat, m_beat());
      chk(int'(tbl_addr) == m_addr, "R3/R8 tbl_addr", tbl_addr, m_addr);
   endtask

   task automatic do_reset();
      act_vld = 1'b0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic good_bit();
      return sig_mem[m_addr];
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < SIG_LEN; i++) sig_mem[i] = 1'($urandom);
      sig_mem[1] = ~sig_mem[0];
      @(negedge clk);
      do_reset();
      chk(tbl_addr == '0, "R1 reset address", tbl_addr, 0);
      chk(beat == 2'b10, "R1 reset beat", beat, 2);

      // R2 first change exactly HALF edges after release, idle with garbage bits (R8)
      for (int i = 0; i < HALF - 1; i++) cyc(1'b0, 1'($urandom));
      chk(beat == 2'b10, "R2 before first boundary", beat, 2);
      cyc(1'b0, 1'($urandom));
      chk(beat == 2'b01, "R2 first boundary", beat, 1);
      chk(tbl_addr == '0, "R8 idle bits ignored", tbl_addr, 0);

      // R3 directed wrap across a non power-of-two length
      for (int i = 0; i < SIG_LEN; i++) cyc(1'b1, good_bit());
      chk(tbl_addr == '0, "R3 wrap to zero", tbl_addr, 0);

      // Random healthy traffic
      for (int i = 0; i < 3000; i++) begin
         logic v;
         v = 1'($urandom);
         cyc(v, v ? good_bit() : 1'($urandom));
      end
      chk(beat != 2'b00, "R2 still alive after random run", beat, 1);

      // R4/R5 mismatch episodes
      for (int e = 0; e < 5; e++) begin
         int  run;
         logic [AW-1:0] frozen;
         do_reset();
         run = 20 + int'($urandom % 150);
         for (int i = 0; i < run; i++) begin
            logic v;
            v = 1'($urandom);
            cyc(v, v ? good_bit() : 1'($urandom));
         end
         cyc(1'b1, ~good_bit());
         chk(beat == 2'b00, "R4 flatline after mismatch", beat, 0);
         frozen = tbl_addr;
         for (int i = 0; i < 60; i++) begin
            logic v;
            v = 1'($urandom);
            cyc(v, 1'($urandom));
         end
         chk(beat == 2'b00, "R5 flatline held", beat, 0);
         chk(tbl_addr == frozen, "R5 address frozen", tbl_addr, frozen);
      end

      // R6 stall timeout at the exact edge
      do_reset();
      for (int i = 0; i < TMO * HALF - 1; i++) cyc(1'b0, 1'b0);
      chk(beat != 2'b00, "R6 alive one edge before timeout", beat, 1);
      cyc(1'b0, 1'b0);
      chk(beat == 2'b00, "R6 timeout flatline", beat, 0);

      // R6 valid on a boundary cycle restarts the count
      do_reset();
      for (int i = 0; i < TMO * HALF - 1; i++) cyc(1'b0, 1'b0);
      cyc(1'b1, good_bit());
      for (int i = 0; i < TMO * HALF - 1; i++) cyc(1'b0, 1'b0);
      chk(beat != 2'b00, "R6 restart on valid bit", beat, 1);

      // R9 corrupted table address
      do_reset();
      stuck = 1'b1;
      for (int i = 0; i < 4; i++) cyc(1'b1, good_bit());
      chk(beat == 2'b00, "R9 stuck address flatline", beat, 0);
      stuck = 1'b0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule